// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Checker

This block sits behind an E1 frame synchronizer and checks the CRC-4 of the received serial stream. It takes one bit per cycle in which `bit_en` is high. The synchronizer supplies a strobe on the first bit of every frame and a strobe on the first bit of every multiframe. A multiframe is two submultiframes of eight frames each. The block runs a four-bit CRC over each submultiframe. At the end of the following submultiframe it compares that result with the four check bits carried there.

Every submultiframe whose check bits disagree in any position counts as one error. Each such error produces a one-cycle pulse and advances a saturating error counter. A host reads the counter with a single-cycle request. The read returns the value and clears the counter in the same step, and an error that lands on that cycle still counts.

Checking runs only while it is switched on and the selected multiframe format carries CRC-4. Whenever there is no trustworthy earlier result, the next comparison is skipped. This covers a fresh alignment, a realignment, a frame slip and re-enabling.

Top module: `e1_crc4_checker`

## Requirements
- R1: Errors are counted and pulsed only while both `crc_en` and `fmt_crc4` are 1; with either at 0, no submultiframe produces a pulse or a count.
- R2: The check value of a submultiframe (8 frames of FRAME_BITS bits) is the remainder of M(x)·x^4 divided by x^4+x+1. M is the submultiframe's bits in arrival order, first bit as the highest power, with the four check-bit positions forced to 0. Those positions are bit 0 of frames 0, 2, 4 and 6 of the submultiframe. The bit in frame 0 carries the x^3 coefficient, and the bit in frame 6 carries the x^0 coefficient.
- R3: The value computed over submultiframe n is compared with the check bits received in submultiframe n+1. One, two, three or four differing bits all produce exactly one error.
- R4: `err_pulse` is high for exactly one cycle, the cycle after the last bit of the submultiframe whose comparison failed.
- R5: The first comparison after alignment is gained, or after checking is switched back on, is skipped.
- R6: `mf_start` with `bit_en` marks bit 0 of frame 0 of a submultiframe pair. If it arrives while the block is unaligned, or at any other position than the expected one, the block realigns there, restarts the CRC, and skips the next comparison.
- R7: Before the first `mf_start`, and after a `frame_start` on a bit that is not bit 0 of a frame, the block is unaligned and counts nothing until the next `mf_start`.
- R8: The counter saturates at 2^CNT_W−1; further errors leave it there.
- R9: A `rd_req` cycle makes `rd_valid` high in the next cycle, with `rd_data` equal to the count before the request. The counter then holds 1 if an error was counted in the request cycle, and 0 otherwise.
- R10: Cycles with `bit_en` low change nothing, whatever `rx_bit`, `frame_start` and `mf_start` carry.
- R11: After reset the counter is 0 and `err_pulse` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `rx_bit` and both strobes for this cycle |
| rx_bit | input | 1 | Received line bit |
| frame_start | input | 1 | Current bit is bit 0 of a frame |
| mf_start | input | 1 | Current bit is bit 0 of a multiframe |
| crc_en | input | 1 | Checking switched on |
| fmt_crc4 | input | 1 | Selected multiframe format carries CRC-4 |
| rd_req | input | 1 | Read-and-clear request for the counter |
| err_pulse | output | 1 | One-cycle pulse per failed comparison |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| rd_data | output | CNT_W | Counter value captured by the request |

## Verification
The two functions that can meet in one cycle are the counter's increment from a failed comparison and the host's read-and-clear. The bench places `rd_req` on the very cycle that carries the last bit of a corrupted submultiframe. It then requires the returned value to be the count from before that submultiframe. A follow-up read must return exactly one. A second collision arises between realignment and the pending comparison. Here the bench cuts a submultiframe short, or shifts the frame strobe, just before a corrupted one, and requires that the skipped comparison yields neither a pulse nor a count.

// File: rtl/e1c_pkg.sv
package e1c_pkg;
  // frames per CRC submultiframe and per multiframe, fixed by the CRC-4 layout
  localparam int SMF_FRAMES = 8;
  localparam int MF_FRAMES  = 2 * SMF_FRAMES;

  typedef logic [3:0] crc4_t;

  // one serial step of the remainder of M(x)*x^4 mod x^4+x+1
  function automatic crc4_t crc4_step(input crc4_t s, input logic b);
    logic fb;
    fb = b ^ s[3];
    return {s[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction

  // saturating increment
  function automatic logic [63:0] sat_inc(input logic [63:0] v, input logic [63:0] top);
    return (v == top) ? v : v + 64'd1;
  endfunction
endpackage

// File: rtl/e1c_align.sv
module e1c_align
  import e1c_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_start,
  input  logic       mf_start,
  output logic       is_c,
  output logic [1:0] c_idx,
  output logic       smf_last,
  output logic       trk,
  output logic       resync
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(MF_FRAMES);
  localparam int SW = $clog2(SMF_FRAMES);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(MF_FRAMES - 1);
  localparam logic [SW-1:0] SMF_LAST = SW'(SMF_FRAMES - 1);

  logic [BW-1:0] bit_q, eff_bit;
  logic [FW-1:0] frm_q, eff_frm;
  logic [SW-1:0] smf_frm;
  logic          aligned_q, mf_hit, slip;

  always_comb begin
    mf_hit  = bit_en & mf_start;
    resync  = mf_hit & (!aligned_q || bit_q != '0 || frm_q != '0);
    slip    = bit_en & frame_start & !mf_start & (bit_q != '0);
    eff_bit = mf_hit ? '0 : bit_q;
    eff_frm = mf_hit ? '0 : frm_q;
    smf_frm = eff_frm[SW-1:0];
    is_c    = (eff_bit == '0) && !smf_frm[0];
    c_idx   = smf_frm[2:1];
    smf_last = (eff_bit == BIT_LAST) && (smf_frm == SMF_LAST);
    trk     = mf_hit | (aligned_q & !slip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      frm_q     <= '0;
      aligned_q <= 1'b0;
    end else if (bit_en) begin
      if (eff_bit == BIT_LAST) begin
        bit_q <= '0;
        frm_q <= (eff_frm == FRM_LAST) ? '0 : eff_frm + 1'b1;
      end else begin
        bit_q <= eff_bit + 1'b1;
        frm_q <= eff_frm;
      end
      if (mf_hit)    aligned_q <= 1'b1;
      else if (slip) aligned_q <= 1'b0;
    end
  end

  // R6
  resync_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (aligned_q && frm_q == '0 && bit_q == BW'(1)));
  // R7
  slip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !aligned_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_q) && $stable(frm_q) && $stable(aligned_q)));
  // R2
  cpos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_c, smf_last}));
endmodule

// File: rtl/e1c_crc_core.sv
module e1c_crc_core
  import e1c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       act,
  input  logic       is_c,
  input  logic [1:0] c_idx,
  input  logic       smf_last,
  input  logic       trk,
  input  logic       resync,
  output logic       mismatch_evt
);
  crc4_t crc_q, ref_q, rxc_q, seed, nxt;
  logic  ref_ok_q, live, cmp_fire;

  always_comb begin
    live     = bit_en & trk;
    seed     = resync ? 4'b0000 : crc_q;
    nxt      = crc4_step(seed, is_c ? 1'b0 : rx_bit);
    cmp_fire = live & smf_last & act & ref_ok_q;
    mismatch_evt = cmp_fire & (ref_q != rxc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      ref_q <= '0;
      rxc_q <= '0;
    end else if (live) begin
      crc_q <= smf_last ? 4'b0000 : nxt;
      if (is_c)     rxc_q[3 - c_idx] <= rx_bit;
      if (smf_last) ref_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ref_ok_q <= 1'b0;
    else if (!act)                   ref_ok_q <= 1'b0;
    else if (bit_en && (!trk || resync)) ref_ok_q <= 1'b0;
    else if (live && smf_last)       ref_ok_q <= 1'b1;
  end

  // R5
  resync_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && resync) |=> !ref_ok_q);
  // R1
  off_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !ref_ok_q);
  // R7
  untracked_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !trk) |=> !ref_ok_q);
  // R3
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |-> (smf_last && bit_en));
endmodule

// File: rtl/e1c_err_cnt.sv
module e1c_err_cnt
  import e1c_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_req,
  output logic             err_pulse,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= inc;
      rd_valid  <= rd_req;
      if (rd_req) begin
        rd_data <= cnt_q;
        cnt_q   <= inc ? CNT_W'(1) : '0;
      end else if (inc) begin
        cnt_q <= CNT_W'(sat_inc(64'(cnt_q), 64'(CNT_MAX)));
      end
    end
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !rd_req) |=> cnt_q == CNT_MAX);
  // R4
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !rd_req && cnt_q != CNT_MAX) |=> (err_pulse && cnt_q == $past(cnt_q) + 1'b1));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_data == $past(cnt_q) && cnt_q == CNT_W'($past(inc))));
  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/e1_crc4_checker.sv
module e1_crc4_checker
  import e1c_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             frame_start,
  input  logic             mf_start,
  input  logic             crc_en,
  input  logic             fmt_crc4,
  input  logic             rd_req,
  output logic             err_pulse,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  logic       is_c, smf_last, trk, resync, mismatch_evt, act;
  logic [1:0] c_idx;

  assign act = crc_en & fmt_crc4;

  e1c_align #(.FRAME_BITS(FRAME_BITS)) u_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .frame_start(frame_start), .mf_start(mf_start),
    .is_c(is_c), .c_idx(c_idx), .smf_last(smf_last),
    .trk(trk), .resync(resync)
  );

  e1c_crc_core u_core (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .act(act),
    .is_c(is_c), .c_idx(c_idx), .smf_last(smf_last), .trk(trk),
    .resync(resync), .mismatch_evt(mismatch_evt)
  );

  e1c_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(mismatch_evt), .rd_req(rd_req),
    .err_pulse(err_pulse), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!err_pulse && !rd_valid));
endmodule

// File: tb/e1_crc4_checker_tb.sv
`timescale 1ns/1ps
module e1_crc4_checker_tb;
  localparam int FB    = 8;
  localparam int CW    = 4;
  localparam int NBITS = 8 * FB;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, rx_bit = 0, frame_start = 0, mf_start = 0;
  logic crc_en = 0, fmt_crc4 = 0, rd_req = 0;
  logic err_pulse, rd_valid;
  logic [CW-1:0] rd_data;

  int checks = 0, fails = 0, pulses = 0, exp_cnt = 0;
  logic [3:0] prev_crc = '0;
  bit prev_ok = 0, bm_al = 0, smf_idx = 0, done = 0;

  always #2 clk = ~clk;

  e1_crc4_checker #(.FRAME_BITS(FB), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .mf_start(mf_start), .crc_en(crc_en),
    .fmt_crc4(fmt_crc4), .rd_req(rd_req), .err_pulse(err_pulse),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(negedge clk) if (err_pulse) pulses++;

  task automatic chk(input bit ok, input string req, input int actual, input int expct);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expct);
    end
  endtask

  function automatic bit cpos(input int i);
    return ((i % FB) == 0) && (((i / FB) % 2) == 0);
  endfunction

  // long division by 10011 over the message followed by four zeros
  function automatic logic [3:0] ref_crc(input logic [NBITS-1:0] d);
    logic [NBITS+3:0] w;
    w = '0;
    for (int i = 0; i < NBITS; i++) w[NBITS + 3 - i] = cpos(i) ? 1'b0 : d[i];
    for (int k = NBITS + 3; k >= 4; k--)
      if (w[k]) w[k -: 5] = w[k -: 5] ^ 5'b10011;
    return w[3:0];
  endfunction

  task automatic send_smf(input logic [3:0] cmask, input int len, input bit use_mf,
                          input bit read_end, input bit gaps, input string req);
    logic [NBITS-1:0] d;
    logic [3:0] sent, crc;
    int p0, old_cnt;
    bit e, act;
    for (int i = 0; i < NBITS; i++) d[i] = 1'($urandom & 1);
    crc  = ref_crc(d);
    sent = prev_crc ^ cmask;
    act  = crc_en & fmt_crc4;
    if (use_mf) bm_al = 1;
    p0 = pulses;
    old_cnt = exp_cnt;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        bit_en = 0; rx_bit = 1'($urandom & 1);
        frame_start = 1'($urandom & 1); mf_start = 1'($urandom & 1); rd_req = 0;
      end
      @(negedge clk);
      bit_en = 1;
      rx_bit = cpos(i) ? sent[3 - (i / (2 * FB))] : d[i];
      frame_start = (i % FB) == 0;
      mf_start = use_mf && (i == 0);
      rd_req = read_end && (i == len - 1);
    end
    @(negedge clk);
    bit_en = 0; frame_start = 0; mf_start = 0; rd_req = 0;
    #1;
    e = (len == NBITS) && act && bm_al && prev_ok && (cmask != 0);
    chk((pulses - p0) == int'(e), req, pulses - p0, int'(e));
    if (read_end) begin
      chk(rd_valid === 1'b1 && int'(rd_data) == old_cnt, "R9 coincident read", int'(rd_data), old_cnt);
      exp_cnt = int'(e);
    end else if (e && exp_cnt < CMAX) exp_cnt++;
    if (len == NBITS) begin
      smf_idx = ~smf_idx;
      if (bm_al) begin prev_crc = crc; prev_ok = act; end
      else prev_ok = 0;
    end
  endtask

  task automatic run(input int n, input logic [3:0] cmask, input string req);
    for (int k = 0; k < n; k++) send_smf(cmask, NBITS, smf_idx == 0, 0, k[0], req);
  endtask

  task automatic do_read(input string req);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    #1;
    chk(rd_valid === 1'b1 && int'(rd_data) == exp_cnt, req, int'(rd_data), exp_cnt);
    exp_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11
    chk(err_pulse === 1'b0, "R11 pulse low", int'(err_pulse), 0);
    chk(rd_valid === 1'b0, "R11 valid low", int'(rd_valid), 0);
    do_read("R11 count zero");
    crc_en = 1; fmt_crc4 = 1;
    // R7: unaligned before any multiframe strobe
    send_smf(4'hF, NBITS, 0, 0, 0, "R7 unaligned");
    send_smf(4'hF, NBITS, 0, 0, 1, "R7 unaligned");
    smf_idx = 0;
    // R5: first comparison after alignment skipped
    send_smf(4'hF, NBITS, 1, 0, 0, "R5 first after align");
    // R2: correct check bits give no error
    run(4, 4'h0, "R2 clean");
    do_read("R2 clean count");
    // R3: every mismatch pattern counts once, with idle cycles mixed in (R10)
    for (int m = 1; m < 16; m++) send_smf(4'(m), NBITS, smf_idx == 0, 0, m[0], "R3 mask");
    do_read("R3 R10 count");
    // R8: saturation
    run(18, 4'h5, "R8 saturate");
    do_read("R8 saturated");
    // R9: increment on the read cycle
    run(2, 4'h8, "R9 pre");
    send_smf(4'h3, NBITS, smf_idx == 0, 1, 0, "R9 collide");
    do_read("R9 after collide");
    // R1: disabled either way
    crc_en = 0;
    run(2, 4'hF, "R1 crc off");
    crc_en = 1;
    run(2, 4'h2, "R1 R5 re-enable");
    fmt_crc4 = 0;
    run(1, 4'h4, "R1 fmt off");
    fmt_crc4 = 1;
    run(2, 4'h1, "R1 R5 fmt back");
    do_read("R1 count");
    // R6: strobe at a foreign position realigns and skips
    send_smf(4'h0, 20, 0, 0, 0, "R6 partial");
    smf_idx = 0; prev_ok = 0;
    run(2, 4'h6, "R6 resync");
    do_read("R6 count");
    // R7: frame slip drops alignment
    send_smf(4'h0, 5, 0, 0, 0, "R7 partial");
    bm_al = 0; prev_ok = 0;
    send_smf(4'hF, NBITS, 0, 0, 0, "R7 slipped");
    smf_idx = 0;
    run(1, 4'h9, "R7 realign");
    run(1, 4'h0, "R7 clean");
    run(1, 4'hA, "R7 counted");
    do_read("R7 count");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule